// File: doc/BRIEF.md
# Power management status/enable register bank

This block is a bank of byte-wide power management registers. It answers a 64-byte I/O window. It keeps four event status registers, and an event input can set each of their bits. Software clears a status bit by writing a 1 to it, and each register has its own mask of clearable bits. It also keeps one enable register, which stores only certain bits. Reads return data in the same cycle as the address. The byte at offset 0x18 is built at read time: it summarises the other status registers and the current system-management state.

A system control interrupt (SCI) rises when a status bit that can raise an interrupt is both set and enabled. The interrupt level is registered. A mode input routes it either to a PCI interrupt pin or to the legacy IRQ9 line.

Top module: `pm_regbank`

## Requirements
- R1: Only address bits [5:0] are decoded, so an access at any address with upper bits set behaves exactly like an access at its low-6-bit offset.
- R2: A write to byte 0x00 or 0x01 clears the written-1 bits of the 16-bit PM status register, but only bits inside mask 0x8D31 (byte 0x01 carries bits 15:8). A write never sets a status bit.
- R3: Writes to bytes 0x02/0x03 load the PM enable register. Only bits inside mask 0x0521 are kept, and the other bits read as 0.
- R4: GP status (bytes 0x0C/0x0D) clears within mask 0x0F81. Global status (bytes 0x18/0x19) clears within mask 0x0DF7. Device status (bytes 0x1C..0x1F, little-endian) clears within mask 0x3FFF0FFF. Each event input sets bits of its register only inside that same mask.
- R5: The SCI level is asserted one cycle after (PM status AND PM enable AND 0x0521) becomes nonzero, and it drops one cycle after that term becomes zero. The mask bits are timer overflow (bit 0), global (bit 5), power button (bit 8) and RTC (bit 10).
- R6: When irq_mode equals 1, the SCI level drives sci_pci and sci_irq9 is low. For any other value of irq_mode, it drives sci_irq9 and sci_pci is low.
- R7: A read of byte 0x18 returns:
  - the stored bits 0 and 2;
  - bit 4 when device status is nonzero;
  - bit 5 while in_smm is high;
  - bit 6 when PM status is nonzero;
  - bit 7 when GP status is nonzero;
  - zeros in all other bits.
- R8: Reads of device status always show bit 28 (byte 0x1F, bit 4) as set.
- R9: After reset, PM status is 0x0100, all other registers are zero and both interrupt outputs are low.
- R10: If an event sets a bit in the same cycle that a write-1 clears it, the bit ends up set.
- R11: Offsets that hold no register read as 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] are decoded |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, available in the same cycle |
| pm_evt | input | 16 | One-cycle set pulses for PM status bits |
| gp_evt | input | 16 | One-cycle set pulses for GP status bits |
| glb_evt | input | 16 | One-cycle set pulses for global status bits |
| dev_evt | input | 32 | One-cycle set pulses for device status bits |
| in_smm | input | 1 | High while the processor is in system management mode |
| irq_mode | input | 2 | Interrupt routing select; value 1 selects the PCI pin |
| sci_pci | output | 1 | SCI on the PCI interrupt pin |
| sci_irq9 | output | 1 | SCI as the IRQ9 level |

## Verification
Read data depends only on the current address and register state, so it is due in the same cycle. A write or event takes effect at the next rising edge and shows in reads from then on. The SCI outputs trail the register state by one more edge, because the interrupt level is registered, while the routing between the two outputs follows irq_mode at once. The bench drives at the falling edge and samples 2 ns later, before the next rising edge. It then updates its reference model just after that rising edge and keeps the model's SCI one register stage behind the model's status and enable values.

// File: rtl/pm_regbank_pkg.sv
// Package: shared offsets, masks and reset values of the power management bank.
// Assumes byte offsets within a 64-byte window.
package pm_regbank_pkg;
    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_PM_STS  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_PM_EN   = 6'h02;
    localparam logic [OFS_W-1:0] OFS_GP_STS  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_GLB_STS = 6'h18;
    localparam logic [OFS_W-1:0] OFS_DEV_STS = 6'h1C;

    localparam logic [15:0] PM_STS_MASK  = 16'h8D31;
    localparam logic [15:0] PM_EN_MASK   = 16'h0521;
    localparam logic [15:0] GP_STS_MASK  = 16'h0F81;
    localparam logic [15:0] GLB_STS_MASK = 16'h0DF7;
    localparam logic [31:0] DEV_STS_MASK = 32'h3FFF_0FFF;

    localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
    localparam logic [15:0] PM_STS_RST   = 16'h0100;
    localparam logic [31:0] DEV_RD_FORCE = 32'h1000_0000;

    localparam logic [1:0]  MODE_PCI     = 2'd1;
endpackage

// File: rtl/pm_w1c_reg.sv
// Module: a status register that is written one byte at a time. Software clears
// bits by writing 1 to them, limited to CLR_MASK. Event pulses set bits, limited
// to SET_MASK, and a set wins over a clear in the same cycle.
// Assumes W is a multiple of 8 and the register lies at BASE..BASE+W/8-1.
module pm_w1c_reg #(
    parameter int           W        = 16,
    parameter logic [5:0]   BASE     = 6'h00,
    parameter logic [W-1:0] CLR_MASK = '1,
    parameter logic [W-1:0] SET_MASK = '1,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [5:0]   wr_ofs,
    input  logic [7:0]   wr_data,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q
);
    localparam int NB = W / 8;

    logic [W-1:0] clr_vec;

    // Byte lanes: place the write data in the lane that is addressed
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign clr_vec[b*8 +: 8] = (wr_en && (wr_ofs == BASE + 6'(b))) ? wr_data : 8'h00;
    end

    // State update: clear masked written-1 bits, then apply event sets
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= (q & ~(clr_vec & CLR_MASK)) | (set_i & SET_MASK);
    end
endmodule

// File: rtl/pm_mask_reg.sv
// Module: a read/write register that is written one byte at a time. It keeps
// only the bits in KEEP_MASK. Assumes W is a multiple of 8.
module pm_mask_reg #(
    parameter int           W         = 16,
    parameter logic [5:0]   BASE      = 6'h02,
    parameter logic [W-1:0] KEEP_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [5:0]   wr_ofs,
    input  logic [7:0]   wr_data,
    output logic [W-1:0] q
);
    localparam int NB = W / 8;

    logic [W-1:0] nxt;

    // Byte lanes: replace the addressed byte, keep the others
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign nxt[b*8 +: 8] = (wr_en && (wr_ofs == BASE + 6'(b))) ? wr_data : q[b*8 +: 8];
    end

    // State update: store only the bits that are allowed to be written
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt & KEEP_MASK;
    end
endmodule

// File: rtl/pm_sci_route.sv
// Module: registers the interrupt level from status AND enable, then steers it
// to the PCI pin or to IRQ9. Assumes mode value MODE_PCI selects the PCI pin.
module pm_sci_route
    import pm_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sts,
    input  logic [15:0] en,
    input  logic [1:0]  mode,
    output logic        sci_pci,
    output logic        sci_irq9
);
    logic sci_q;

    // Level register: recomputed every cycle from current state
    always_ff @(posedge clk) begin
        if (!rst_n) sci_q <= 1'b0;
        else        sci_q <= |(sts & en & SCI_SRC_MASK);
    end

    // Routing: exactly one destination may carry the level
    always_comb begin
        sci_pci  = sci_q && (mode == MODE_PCI);
        sci_irq9 = sci_q && (mode != MODE_PCI);
    end
endmodule

// File: rtl/pm_regbank.sv
// Module: top of the power management register bank. It decodes a 64-byte
// window (low 6 address bits), holds the status and enable registers, builds the
// global summary byte, and raises the SCI. Assumes one byte per access, with
// read data given in the same cycle as the address.
module pm_regbank
    import pm_regbank_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [15:0]       pm_evt,
    input  logic [15:0]       gp_evt,
    input  logic [15:0]       glb_evt,
    input  logic [31:0]       dev_evt,
    input  logic              in_smm,
    input  logic [1:0]        irq_mode,
    output logic              sci_pci,
    output logic              sci_irq9
);
    logic [OFS_W-1:0] ofs;
    logic             unused_addr_hi;
    logic [15:0]      pm_sts_q, pm_en_q, gp_sts_q, glb_sts_q;
    logic [31:0]      dev_sts_q, dev_rd;
    logic [7:0]       glb_sum;

    assign ofs            = bus_addr[OFS_W-1:0];
    assign unused_addr_hi = ^bus_addr;

    pm_w1c_reg #(.W(16), .BASE(OFS_PM_STS), .CLR_MASK(PM_STS_MASK),
                 .SET_MASK(PM_STS_MASK), .RST_VAL(PM_STS_RST)) u_pm_sts (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(ofs),
        .wr_data(bus_wdata), .set_i(pm_evt), .q(pm_sts_q));

    pm_mask_reg #(.W(16), .BASE(OFS_PM_EN), .KEEP_MASK(PM_EN_MASK)) u_pm_en (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(ofs),
        .wr_data(bus_wdata), .q(pm_en_q));

    pm_w1c_reg #(.W(16), .BASE(OFS_GP_STS), .CLR_MASK(GP_STS_MASK),
                 .SET_MASK(GP_STS_MASK), .RST_VAL(16'h0)) u_gp_sts (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(ofs),
        .wr_data(bus_wdata), .set_i(gp_evt), .q(gp_sts_q));

    pm_w1c_reg #(.W(16), .BASE(OFS_GLB_STS), .CLR_MASK(GLB_STS_MASK),
                 .SET_MASK(GLB_STS_MASK), .RST_VAL(16'h0)) u_glb_sts (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(ofs),
        .wr_data(bus_wdata), .set_i(glb_evt), .q(glb_sts_q));

    pm_w1c_reg #(.W(32), .BASE(OFS_DEV_STS), .CLR_MASK(DEV_STS_MASK),
                 .SET_MASK(DEV_STS_MASK), .RST_VAL(32'h0)) u_dev_sts (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(ofs),
        .wr_data(bus_wdata), .set_i(dev_evt), .q(dev_sts_q));

    pm_sci_route u_sci (
        .clk(clk), .rst_n(rst_n), .sts(pm_sts_q), .en(pm_en_q),
        .mode(irq_mode), .sci_pci(sci_pci), .sci_irq9(sci_irq9));

    // Summary byte: stored bits 2 and 0 plus live flags for the other registers
    always_comb begin
        glb_sum = {|gp_sts_q, |pm_sts_q, in_smm, |dev_sts_q,
                   1'b0, glb_sts_q[2], 1'b0, glb_sts_q[0]};
        dev_rd  = dev_sts_q | DEV_RD_FORCE;
    end

    // Read mux: pick the addressed byte, zero for offsets with no register
    always_comb begin
        case (ofs)
            6'h00:   bus_rdata = pm_sts_q[7:0];
            6'h01:   bus_rdata = pm_sts_q[15:8];
            6'h02:   bus_rdata = pm_en_q[7:0];
            6'h03:   bus_rdata = pm_en_q[15:8];
            6'h0C:   bus_rdata = gp_sts_q[7:0];
            6'h0D:   bus_rdata = gp_sts_q[15:8];
            6'h18:   bus_rdata = glb_sum;
            6'h19:   bus_rdata = glb_sts_q[15:8];
            6'h1C:   bus_rdata = dev_rd[7:0];
            6'h1D:   bus_rdata = dev_rd[15:8];
            6'h1E:   bus_rdata = dev_rd[23:16];
            6'h1F:   bus_rdata = dev_rd[31:24];
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pm_regbank_chk.sv
// Checker: temporal properties of the power management bank, attached by bind.
module pm_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [5:0]  ofs,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] pm_evt,
    input logic [15:0] pm_sts_q,
    input logic [15:0] pm_en_q,
    input logic        in_smm,
    input logic [1:0]  irq_mode,
    input logic        sci_pci,
    input logic        sci_irq9
);
    // R2: with no event pending, a cycle never adds a PM status bit
    a_r2_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_evt == 16'h0) |=> ((pm_sts_q & ~$past(pm_sts_q)) == 16'h0));

    // R10: a set in the same cycle as a write-1 clear leaves the bit set
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_evt[0] && bus_wr && ofs == 6'h00 && bus_wdata[0]) |=> pm_sts_q[0]);

    // R5: interrupt level follows the enabled sources one cycle later
    a_r5_sci_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sci_pci | sci_irq9) == |($past(pm_sts_q & pm_en_q) & 16'h0521)));

    // R6: never both destinations; PCI mode keeps IRQ9 quiet
    a_r6_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sci_pci, sci_irq9}));
    a_r6_pci_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'd1) |-> !sci_irq9);

    // R7: SMM flag in the summary byte mirrors the input
    a_r7_smm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == 6'h18) |-> (bus_rdata[5] == in_smm));

    // R8: device status top byte always shows bit 28
    a_r8_dev_bit28: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == 6'h1F) |-> bus_rdata[4]);

    // R9: first cycle after reset holds the reset values
    a_r9_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pm_sts_q == 16'h0100 && !sci_pci && !sci_irq9));
endmodule

bind pm_regbank pm_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .ofs(bus_addr[5:0]),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pm_evt(pm_evt),
    .pm_sts_q(pm_sts_q), .pm_en_q(pm_en_q), .in_smm(in_smm),
    .irq_mode(irq_mode), .sci_pci(sci_pci), .sci_irq9(sci_irq9));

// File: tb/pm_regbank_bench.sv
// Bench: directed corner cases and seeded random traffic checked against a model.
module pm_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pm_evt = '0, gp_evt = '0, glb_evt = '0;
    logic [31:0] dev_evt = '0;
    logic        in_smm = 1'b0;
    logic [1:0]  irq_mode = 2'd0;
    logic        sci_pci, sci_irq9;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_pm, m_en, m_gp, m_glb;
    logic [31:0] m_dev;
    logic        m_sci;

    always #4 clk = ~clk;

    pm_regbank u_pm_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pm_evt(pm_evt),
        .gp_evt(gp_evt), .glb_evt(glb_evt), .dev_evt(dev_evt), .in_smm(in_smm),
        .irq_mode(irq_mode), .sci_pci(sci_pci), .sci_irq9(sci_irq9));

    function automatic logic [7:0] rd_model(input logic [15:0] addr, input logic smm);
        logic [31:0] d;
        d = m_dev | 32'h1000_0000;
        case (addr[5:0])
            6'h00: return m_pm[7:0];
            6'h01: return m_pm[15:8];
            6'h02: return m_en[7:0];
            6'h03: return m_en[15:8];
            6'h0C: return m_gp[7:0];
            6'h0D: return m_gp[15:8];
            6'h18: return {m_gp != 0, m_pm != 0, smm, m_dev != 0, 1'b0, m_glb[2], 1'b0, m_glb[0]};
            6'h19: return m_glb[15:8];
            6'h1C: return d[7:0];
            6'h1D: return d[15:8];
            6'h1E: return d[23:16];
            6'h1F: return d[31:24];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_for(input logic [15:0] addr);
        if (addr[15:6] != 0) return "R1";
        case (addr[5:0])
            6'h00, 6'h01: return "R2";
            6'h02, 6'h03: return "R3";
            6'h0C, 6'h0D, 6'h19: return "R4";
            6'h18: return "R7";
            6'h1C, 6'h1D, 6'h1E, 6'h1F: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_update(input logic wr, input logic [5:0] a, input logic [7:0] d,
                                input logic [15:0] pe, ge, gle, input logic [31:0] de);
        logic [15:0] c_pm, c_gp, c_glb, e;
        logic [31:0] c_dev;
        logic nsci;
        nsci = |(m_pm & m_en & 16'h0521);
        c_pm = '0; c_gp = '0; c_glb = '0; c_dev = '0; e = m_en;
        if (wr) begin
            if (a == 6'h00) c_pm[7:0] = d;
            if (a == 6'h01) c_pm[15:8] = d;
            if (a == 6'h02) e[7:0] = d;
            if (a == 6'h03) e[15:8] = d;
            if (a == 6'h0C) c_gp[7:0] = d;
            if (a == 6'h0D) c_gp[15:8] = d;
            if (a == 6'h18) c_glb[7:0] = d;
            if (a == 6'h19) c_glb[15:8] = d;
            if (a == 6'h1C) c_dev[7:0] = d;
            if (a == 6'h1D) c_dev[15:8] = d;
            if (a == 6'h1E) c_dev[23:16] = d;
            if (a == 6'h1F) c_dev[31:24] = d;
        end
        m_pm  = (m_pm  & ~(c_pm  & 16'h8D31)) | (pe  & 16'h8D31);
        m_gp  = (m_gp  & ~(c_gp  & 16'h0F81)) | (ge  & 16'h0F81);
        m_glb = (m_glb & ~(c_glb & 16'h0DF7)) | (gle & 16'h0DF7);
        m_dev = (m_dev & ~(c_dev & 32'h3FFF_0FFF)) | (de & 32'h3FFF_0FFF);
        m_en  = e & 16'h0521;
        m_sci = nsci;
    endtask

    // One cycle: drive at falling edge, check before rising edge, then update model
    task automatic cyc(input logic wr, input logic [15:0] addr, input logic [7:0] d,
                       input logic [15:0] pe, ge, gle, input logic [31:0] de,
                       input logic smm, input logic [1:0] mode, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_addr = addr; bus_wdata = d;
        pm_evt = pe; gp_evt = ge; glb_evt = gle; dev_evt = de;
        in_smm = smm; irq_mode = mode;
        #2;
        check((tag == "") ? req_for(addr) : tag, {24'h0, bus_rdata}, {24'h0, rd_model(addr, smm)});
        check("R5", {31'h0, sci_pci | sci_irq9}, {31'h0, m_sci});
        check("R6", {30'h0, sci_pci, sci_irq9}, {30'h0, m_sci && mode == 2'd1, m_sci && mode != 2'd1});
        @(posedge clk);
        #1;
        model_update(wr, addr[5:0], d, pe, ge, gle, de);
    endtask

    task automatic rd(input logic [15:0] addr, input logic [1:0] mode, input string tag);
        cyc(1'b0, addr, 8'h00, 16'h0, 16'h0, 16'h0, 32'h0, 1'b0, mode, tag);
    endtask

    task automatic wr(input logic [15:0] addr, input logic [7:0] d, input string tag);
        cyc(1'b1, addr, d, 16'h0, 16'h0, 16'h0, 32'h0, 1'b0, 2'd0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1-R11 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_pm = 16'h0100; m_en = '0; m_gp = '0; m_glb = '0; m_dev = '0; m_sci = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset values
        rd(16'h0001, 2'd0, "R9");
        rd(16'h0000, 2'd0, "R9");
        check("R9", {24'h0, 8'h01}, {24'h0, rd_model(16'h0001, 1'b0)});
        // R3: enable keeps only mask 0x0521
        wr(16'h0002, 8'hFF, "R3");
        wr(16'h0003, 8'hFF, "R3");
        rd(16'h0002, 2'd1, "R3");
        check("R3", {24'h0, m_en[15:8]}, 32'h05);
        // R5/R6: power button bit 8 enabled, route to PCI then IRQ9
        rd(16'h0003, 2'd1, "R5");
        rd(16'h0003, 2'd0, "R6");
        rd(16'h0003, 2'd2, "R6");
        // R2: clear bit 8 by writing 1 to byte 0x01
        wr(16'h0001, 8'hFF, "R2");
        rd(16'h0001, 2'd0, "R2");
        rd(16'h0001, 2'd0, "R5");
        // R10: set and clear of bit 0 in the same cycle
        cyc(1'b1, 16'h0000, 8'h01, 16'h0001, 16'h0, 16'h0, 32'h0, 1'b0, 2'd1, "R10");
        rd(16'h0000, 2'd1, "R10");
        check("R10", {31'h0, m_pm[0]}, 32'h1);
        // R4/R7: GP, global and device events plus SMM summary
        cyc(1'b0, 16'h0018, 8'h00, 16'h0, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 1'b1, 2'd0, "R7");
        cyc(1'b0, 16'h0018, 8'h00, 16'h0, 16'h0, 16'h0, 32'h0, 1'b1, 2'd0, "R7");
        wr(16'h0018, 8'hFF, "R4");
        rd(16'h0019, 2'd0, "R4");
        wr(16'h001F, 8'hFF, "R4");
        rd(16'h001F, 2'd0, "R8");
        // R1: aliased address reaches the same register
        wr(16'h7F4D, 8'hFF, "R1");
        rd(16'h000D, 2'd0, "R1");
        // R11: unmapped offset reads zero after a write
        wr(16'h003A, 8'hFF, "R11");
        rd(16'h003A, 2'd0, "R11");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            a = {(($urandom % 4) == 0) ? 10'($urandom) : 10'h0, 6'($urandom)};
            cyc(1'($urandom), a, 8'($urandom),
                16'($urandom & $urandom & $urandom & $urandom),
                16'($urandom & $urandom & $urandom),
                16'($urandom & $urandom & $urandom),
                $urandom & $urandom & $urandom & $urandom,
                1'($urandom), 2'($urandom), "");
        end
        finish_run();
    end
endmodule